// File: doc/BRIEF.md
# Power-of-Two Clock Prescaler with Glitch-Free Output Gate

This block makes the output clock of a programmable oscillator. It runs on a clock at twice the master oscillator rate. It divides the master rate by a power of two, selected by a 4-bit exponent, and drives an output pin with a data bit and a tristate enable. An output-enable input and a power-run input control the pin. A mode bit chooses what a disabled pin does: it either floats or is driven low.

All gating happens on divided-period boundaries, which is where the divided clock falls. Every high pulse that leaves the block therefore has full width. The block enforces a warm-up delay of a fixed number of master cycles before the first output edge, both after reset and after power is restored. It ignores a power-off request unless the request persists across two consecutive period boundaries.

Top module: `pow2_clock_gate`

## Requirements
- R1: While reset is held and in the first cycle after it, `clk_out` is 0 and `clk_oe` equals `idle_low`.
- R2: With exponent x (0 to 8) the output period is 2^(x+1) block-clock cycles, high for the second 2^x of them. This equals the master rate divided by 2^x.
- R3: An exponent value above 8 divides exactly as 8 does (period 512 block cycles).
- R4: A new exponent is taken only at a period boundary, or while the divider is stopped. No period of mixed length is emitted.
- R5: After reset is released, or after leaving power-off, `clk_out` stays 0 until 1024 block cycles (512 master cycles) have elapsed. With exponent 0 the first high output appears in block cycle 1025 after reset release.
- R6: When `out_en` is low, the divider keeps running and the output is disabled from the next boundary on. Raising `out_en` again resumes output within one period, with no warm-up delay.
- R7: While disabled, the pin floats (`clk_oe`=0) if `idle_low`=0, and is driven low (`clk_oe`=1, `clk_out`=0) if `idle_low`=1.
- R8: The enable and disable of the output change only at a period boundary or at warm-up completion. Every emitted high pulse lasts 2^x cycles.
- R9: While running, `pwr_on` low takes effect only if it is sampled low at two consecutive period boundaries with no high sample between them. A shorter low pulse leaves the output running.
- R10: After power-off, raising `pwr_on` restarts the full warm-up. With exponent 2 the first high output comes 1029 block cycles after `pwr_on` rises.
- R11: A low `pwr_on` during warm-up moves the block to power-off at once. Warm-up then restarts from zero when power returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, twice the master oscillator rate |
| rst | input | 1 | Synchronous active-high reset |
| div_exp | input | 4 | Divide exponent; values above 8 saturate |
| out_en | input | 1 | Output enable; high lets clock pulses out |
| pwr_on | input | 1 | Oscillator run request; low asks for power-off |
| idle_low | input | 1 | Disabled pin state: 1 drive low, 0 float |
| clk_out | output | 1 | Output clock data |
| clk_oe | output | 1 | Tristate enable for the output pin |

## Verification
The bench builds the block with its defaults: maximum exponent 8, warm-up of 512 master cycles, and a two-boundary power-off filter. Because the 4-bit exponent field reaches 15, these defaults put the saturation case within reach. They also give a 1024-cycle warm-up that the bench can count exactly, and a 512-cycle longest period that it can measure edge to edge. A behavioural reference model is compared with both outputs on every cycle, so mid-period exponent changes, gating on boundaries and filtered power requests are all checked for pulse integrity.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
    localparam int EXP_W = 4;

    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_WARM = 2'd1,
        PS_RUN  = 2'd2
    } pstate_e;

    function automatic logic [EXP_W-1:0] sat_exp(input logic [EXP_W-1:0] e,
                                                 input logic [EXP_W-1:0] mx);
        return (e > mx) ? mx : e;
    endfunction
endpackage

// File: rtl/pg_pow2_div.sv
module pg_pow2_div
    import prescale_pkg::*;
#(
    parameter int MAX_EXP = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [EXP_W-1:0] exp_req,
    output logic             dclk,
    output logic             bnd
);
    localparam int HC_W = (MAX_EXP > 0) ? MAX_EXP : 1;
    localparam logic [HC_W-1:0] ONES = {HC_W{1'b1}};

    logic [HC_W-1:0]  hc;
    logic [EXP_W-1:0] x_act;
    logic [HC_W-1:0]  half_lim;
    logic             end_half;
    logic [EXP_W-1:0] x_new;

    assign x_new    = sat_exp(exp_req, EXP_W'(MAX_EXP));
    assign half_lim = ONES >> (EXP_W'(MAX_EXP) - x_act);
    assign end_half = (hc == half_lim);
    assign bnd      = run && end_half && dclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hc    <= '0;
            dclk  <= 1'b0;
            x_act <= x_new;
        end else if (end_half) begin
            hc   <= '0;
            dclk <= !dclk;
            if (dclk) x_act <= x_new;
        end else begin
            hc <= hc + 1'b1;
        end
    end

    // R4
    exp_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$stable(x_act)) |-> $fell(dclk));
endmodule

// File: rtl/pg_power_ctrl.sv
module pg_power_ctrl
    import prescale_pkg::*;
#(
    parameter int STARTUP_CYC = 512,
    parameter int PD_PERIODS  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_on,
    input  logic bnd,
    output logic running,
    output logic launch,
    output logic shutdown
);
    localparam int TICKS = 2 * STARTUP_CYC;
    localparam int CNT_W = $clog2(TICKS);
    localparam int PD_W  = $clog2(PD_PERIODS + 1);

    pstate_e          st;
    logic [CNT_W-1:0] scnt;
    logic [PD_W-1:0]  pdc;

    assign running  = (st == PS_RUN);
    assign launch   = (st == PS_WARM) && pwr_on && (scnt == CNT_W'(TICKS - 1));
    assign shutdown = running && !pwr_on && bnd && (pdc == PD_W'(PD_PERIODS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= PS_WARM;
            scnt <= '0;
            pdc  <= '0;
        end else begin
            case (st)
                PS_OFF: begin
                    if (pwr_on) begin
                        st   <= PS_WARM;
                        scnt <= '0;
                    end
                end
                PS_WARM: begin
                    if (!pwr_on) begin
                        st   <= PS_OFF;
                        scnt <= '0;
                    end else if (launch) begin
                        st  <= PS_RUN;
                        pdc <= '0;
                    end else begin
                        scnt <= scnt + 1'b1;
                    end
                end
                PS_RUN: begin
                    if (pwr_on) begin
                        pdc <= '0;
                    end else if (shutdown) begin
                        st   <= PS_OFF;
                        pdc  <= '0;
                        scnt <= '0;
                    end else if (bnd) begin
                        pdc <= pdc + 1'b1;
                    end
                end
                default: st <= PS_WARM;
            endcase
        end
    end

    // R5
    warmup_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> ($past(scnt) == CNT_W'(TICKS - 1)));

    // R9
    stop_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> ($past(!pwr_on) && $past(bnd)));
endmodule

// File: rtl/pow2_clock_gate.sv
module pow2_clock_gate
    import prescale_pkg::*;
#(
    parameter int MAX_EXP     = 8,
    parameter int STARTUP_CYC = 512,
    parameter int PD_PERIODS  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EXP_W-1:0] div_exp,
    input  logic             out_en,
    input  logic             pwr_on,
    input  logic             idle_low,
    output logic             clk_out,
    output logic             clk_oe
);
    logic dclk, bnd, running, launch, shutdown;
    logic gate_q;

    pg_pow2_div #(.MAX_EXP(MAX_EXP)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .exp_req (div_exp),
        .dclk    (dclk),
        .bnd     (bnd)
    );

    pg_power_ctrl #(.STARTUP_CYC(STARTUP_CYC), .PD_PERIODS(PD_PERIODS)) u_pwr (
        .clk      (clk),
        .rst      (rst),
        .pwr_on   (pwr_on),
        .bnd      (bnd),
        .running  (running),
        .launch   (launch),
        .shutdown (shutdown)
    );

    always_ff @(posedge clk) begin
        if (rst)                 gate_q <= 1'b0;
        else if (shutdown)       gate_q <= 1'b0;
        else if (launch || bnd)  gate_q <= out_en;
    end

    assign clk_out = dclk & gate_q;
    assign clk_oe  = gate_q | idle_low;

    // R8
    gate_edge_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(gate_q) |-> !dclk);

    // R5
    out_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        clk_out |-> running);
endmodule

// File: tb/pow2_clock_gate_test.sv
module pow2_clock_gate_test;
    localparam int CLK_PERIOD = 10;
    localparam int WARM = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] div_exp = 4'd0;
    logic       out_en = 1'b1;
    logic       pwr_on = 1'b1;
    logic       idle_low = 1'b0;
    logic       clk_out, clk_oe;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pow2_clock_gate uut (
        .clk(clk), .rst(rst), .div_exp(div_exp), .out_en(out_en),
        .pwr_on(pwr_on), .idle_low(idle_low), .clk_out(clk_out), .clk_oe(clk_oe)
    );

    // behavioural reference: mode 0 off, 1 warm-up, 2 running
    int  m_mode, m_cnt, m_pdc, m_pos, m_x;
    bit  m_gate;

    function automatic int clampx(input int e);
        return (e > 8) ? 8 : e;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 1; m_cnt = 0; m_pdc = 0; m_pos = 0; m_gate = 0;
            m_x = clampx(int'(div_exp));
        end else begin
            bit run_old, at_end, go, stop;
            run_old = (m_mode == 2);
            at_end  = run_old && (m_pos == (2 << m_x) - 1);
            go      = (m_mode == 1) && pwr_on && (m_cnt == WARM - 1);
            stop    = run_old && !pwr_on && at_end && (m_pdc == 1);
            if (stop) m_gate = 0;
            else if (go || at_end) m_gate = out_en;
            if (!run_old || at_end) begin
                m_pos = 0;
                m_x = clampx(int'(div_exp));
            end else m_pos++;
            case (m_mode)
                0: if (pwr_on) begin m_mode = 1; m_cnt = 0; end
                1: if (!pwr_on) begin m_mode = 0; m_cnt = 0; end
                   else if (go) begin m_mode = 2; m_pdc = 0; end
                   else m_cnt++;
                default: if (pwr_on) m_pdc = 0;
                   else if (stop) begin m_mode = 0; m_pdc = 0; m_cnt = 0; end
                   else if (at_end) m_pdc++;
            endcase
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            bit e_out, e_oe;
            e_out = m_gate && (m_mode == 2) && (m_pos >= (1 << m_x));
            e_oe  = m_gate || idle_low;
            checks++;
            if (clk_out !== e_out || clk_oe !== e_oe) begin
                failures++;
                $display("FAIL R4/R8 cycle model t=%0t out=%b oe=%b expected out=%b oe=%b",
                         $time, clk_out, clk_oe, e_out, e_oe);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic count_rise(output int n);
        n = 0;
        while (clk_out !== 1'b1 && n < 5000) begin
            @(posedge clk); #1; n++;
        end
    endtask

    task automatic measure(output int hi, output int per);
        int w;
        count_rise(w);
        hi = 0;
        while (clk_out === 1'b1 && hi < 5000) begin @(posedge clk); #1; hi++; end
        per = hi;
        while (clk_out !== 1'b1 && per < 5000) begin @(posedge clk); #1; per++; end
    endtask

    initial begin
        int n, hi, per;
        bit stayed_low;
        step(3);
        chk_on = 1'b1;
        // R1 / R7 reset state
        check(clk_out === 1'b0, "R1 reset out", int'(clk_out), 0);
        check(clk_oe === 1'b0, "R7 reset float", int'(clk_oe), 0);
        idle_low = 1'b1; #1;
        check(clk_oe === 1'b1, "R1 reset drive-low oe", int'(clk_oe), 1);
        step(1);
        rst = 1'b0;
        count_rise(n);
        check(n == 1025, "R5 warm-up after reset", n, 1025);
        measure(hi, per);
        check(hi == 1 && per == 2, "R2 exp0 period", per * 100 + hi, 201);

        step(1); div_exp = 4'd3; step(40);
        measure(hi, per);
        check(hi == 8 && per == 16, "R2 exp3 period", per * 100 + hi, 1608);

        step(1); div_exp = 4'd13; step(600);
        measure(hi, per);
        check(hi == 256 && per == 512, "R3 saturated exponent", per * 1000 + hi, 512256);

        step(1); div_exp = 4'd2; step(1100);
        out_en = 1'b0; step(20);
        stayed_low = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (clk_out !== 1'b0) stayed_low = 1'b0;
            step(1);
        end
        check(stayed_low, "R6 disabled output low", int'(stayed_low), 1);
        check(clk_oe === 1'b1, "R7 drive-low idle oe", int'(clk_oe), 1);
        idle_low = 1'b0; step(1);
        check(clk_oe === 1'b0, "R7 float idle oe", int'(clk_oe), 0);
        idle_low = 1'b1; step(1);
        out_en = 1'b1;
        count_rise(n);
        check(n >= 1 && n <= 9, "R6 resume without warm-up", n, 9);

        step(1); pwr_on = 1'b0; step(3); pwr_on = 1'b1; step(20);
        measure(hi, per);
        check(hi == 4 && per == 8, "R9 short power glitch ignored", per * 100 + hi, 804);

        step(1); pwr_on = 1'b0; step(40);
        check(clk_out === 1'b0 && clk_oe === 1'b1, "R9 powered off", int'(clk_out), 0);
        pwr_on = 1'b1;
        count_rise(n);
        check(n == 1029, "R10 warm-up after power-off", n, 1029);

        step(1); rst = 1'b1; div_exp = 4'd0; step(2); rst = 1'b0; step(100);
        pwr_on = 1'b0; step(1); pwr_on = 1'b1;
        count_rise(n);
        check(n == 1026, "R11 off during warm-up restarts count", n, 1026);

        step(4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule